// File: doc/BRIEF.md
# Floating-Point Compare with Condition Code

This block compares two IEEE-754 binary floating-point operands and returns a two-bit condition code that tells whether the first operand is equal to, below, above or unordered with respect to the second. A build-time parameter selects single or double precision. The compare logic is combinational. The condition code, the invalid-operation flag and a trap strobe are registered and appear together with a one-cycle valid pulse. Subnormal operands are ordered as ordinary values, with no flushing.

A per-request mode input chooses between two kinds of compare. The quiet kind reports invalid only when an operand is a signaling NaN. The signaling kind reports invalid for any NaN. The invalid flag then goes through an exception check. If the invalid-trap enable is set, the compare raises a trap and leaves the architectural state unchanged. If it is clear, the result is committed and invalid is folded into a sticky accrued-invalid bit. An unordered result also sets that sticky bit directly, even when no invalid was raised.

Top module: `fpcmp_cc`

## Requirements
- R1: A request accepted with `in_valid` high produces `out_valid` high on the next clock edge. Unless that request traps, `cc_o` then shows the code for the relation of `op_a` to `op_b`: 0 = equal, 1 = op_a below op_b, 2 = op_a above op_b, 3 = unordered.
- R2: Positive zero and negative zero compare as equal (code 0) in either operand order.
- R3: Non-NaN values, including infinities and subnormals, are ordered by sign and then magnitude. When both operands are negative, the order by magnitude is reversed.
- R4: An operand is a NaN when its exponent field is all ones and its fraction is nonzero. It is a signaling NaN when the most significant fraction bit is 0. With `cmp_signaling` = 0 (quiet), `nv_o` is 1 only when at least one operand is a signaling NaN.
- R5: With `cmp_signaling` = 1 (signaling), `nv_o` is 1 whenever at least one operand is any NaN.
- R6: `acc_nv_o` is a sticky bit, cleared only by reset. A committed (non-trapping) request sets it when its result is unordered or when it raised invalid.
- R7: When a request raises invalid and `trap_nv_en` = 1, `trap_o` and `nv_o` pulse with `out_valid`. In that case `cc_o` keeps its previous value and `acc_nv_o` does not change.
- R8: After reset, `out_valid`, `cc_o`, `nv_o`, `trap_o` and `acc_nv_o` are all 0.
- R9: In a cycle after which no request was accepted, `out_valid`, `nv_o` and `trap_o` are 0 and `cc_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A compare request is present this cycle |
| cmp_signaling | input | 1 | 0 = quiet compare, 1 = signaling compare |
| trap_nv_en | input | 1 | Trap enable for the invalid exception |
| op_a | input | W (32 or 64) | First operand |
| op_b | input | W (32 or 64) | Second operand |
| out_valid | output | 1 | Registered result strobe |
| cc_o | output | 2 | Condition code |
| nv_o | output | 1 | Invalid raised by the reported request |
| trap_o | output | 1 | The reported request trapped |
| acc_nv_o | output | 1 | Sticky accrued-invalid bit |

## Verification
The relation decode and the exception check act in the same cycle when a NaN operand arrives. The unordered code and the invalid decision then meet in one status update, and the trap enable decides whether that update is committed or suppressed. The bench provokes this case with a quiet NaN and with a signaling NaN, each with the trap enable set, right after a reset. A correct design commits code 3 and sets the accrued bit for the quiet NaN. For the signaling NaN it traps, keeps the old code and leaves the accrued bit clear.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
  typedef enum logic [1:0] {
    REL_EQ = 2'd0,
    REL_LT = 2'd1,
    REL_GT = 2'd2,
    REL_UN = 2'd3
  } rel_t;
endpackage

// File: rtl/fpcmp_classify.sv
module fpcmp_classify #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] op,
  output logic         sign_o,
  output logic [W-2:0] mag_o,
  output logic         nan_o,
  output logic         snan_o,
  output logic         zero_o
);
  logic [EXP_W-1:0]  expf;
  logic [FRAC_W-1:0] frac;

  assign sign_o = op[W-1];
  assign mag_o  = op[W-2:0];
  assign expf   = op[W-2:FRAC_W];
  assign frac   = op[FRAC_W-1:0];

  always_comb begin
    nan_o  = (&expf) && (|frac);
    snan_o = nan_o && !frac[FRAC_W-1];
    zero_o = (mag_o == '0);
  end
endmodule

// File: rtl/fpcmp_order.sv
module fpcmp_order
  import fpcmp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         sign_a,
  input  logic [W-2:0] mag_a,
  input  logic         nan_a,
  input  logic         zero_a,
  input  logic         sign_b,
  input  logic [W-2:0] mag_b,
  input  logic         nan_b,
  input  logic         zero_b,
  output rel_t         rel_o
);
  logic mag_lt, mag_eq;

  assign mag_lt = (mag_a < mag_b);
  assign mag_eq = (mag_a == mag_b);

  always_comb begin
    if (nan_a || nan_b) begin
      rel_o = REL_UN;
    end else if (zero_a && zero_b) begin
      rel_o = REL_EQ;
    end else if (sign_a != sign_b) begin
      rel_o = sign_a ? REL_LT : REL_GT;
    end else if (mag_eq) begin
      rel_o = REL_EQ;
    end else if (sign_a) begin
      rel_o = mag_lt ? REL_GT : REL_LT;
    end else begin
      rel_o = mag_lt ? REL_LT : REL_GT;
    end
  end
endmodule

// File: rtl/fpcmp_status.sv
module fpcmp_status
  import fpcmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic       cmp_signaling,
  input  logic       trap_nv_en,
  input  rel_t       rel,
  input  logic       any_nan,
  input  logic       any_snan,
  output logic       out_valid,
  output logic [1:0] cc_o,
  output logic       nv_o,
  output logic       trap_o,
  output logic       acc_nv_o
);
  logic raise_nv, take_trap, commit;

  always_comb begin
    raise_nv  = in_valid && (cmp_signaling ? any_nan : any_snan);
    take_trap = raise_nv && trap_nv_en;
    commit    = in_valid && !take_trap;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      cc_o      <= 2'd0;
      nv_o      <= 1'b0;
      trap_o    <= 1'b0;
      acc_nv_o  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      nv_o      <= raise_nv;
      trap_o    <= take_trap;
      if (commit) begin
        cc_o <= rel;
        if (rel == REL_UN || raise_nv) acc_nv_o <= 1'b1;
      end
    end
  end

  // R7: a trapped request leaves the condition code untouched
  p_trap_holds_cc_r7: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> $stable(cc_o));
  // R7: a trap is always accompanied by invalid
  p_trap_needs_nv_r7: assert property (@(posedge clk) disable iff (rst)
    trap_o |-> (nv_o && out_valid));
  // R6: the accrued bit never clears without reset
  p_acc_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    acc_nv_o |=> acc_nv_o);
  // R9: no result strobe without a request
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !trap_o && !nv_o));
endmodule

// File: rtl/fpcmp_cc.sv
module fpcmp_cc
  import fpcmp_pkg::*;
#(
  parameter bit USE_DOUBLE = 1'b0,
  localparam int EXP_W  = USE_DOUBLE ? 11 : 8,
  localparam int FRAC_W = USE_DOUBLE ? 52 : 23,
  localparam int W      = 1 + EXP_W + FRAC_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic         cmp_signaling,
  input  logic         trap_nv_en,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         out_valid,
  output logic [1:0]   cc_o,
  output logic         nv_o,
  output logic         trap_o,
  output logic         acc_nv_o
);
  logic [W-1:0] ops  [2];
  logic         sgn  [2];
  logic [W-2:0] mag  [2];
  logic         nan  [2];
  logic         snan [2];
  logic         zero [2];
  rel_t         rel;

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar gi = 0; gi < 2; gi++) begin : g_cls
    fpcmp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op     (ops[gi]),
      .sign_o (sgn[gi]),
      .mag_o  (mag[gi]),
      .nan_o  (nan[gi]),
      .snan_o (snan[gi]),
      .zero_o (zero[gi])
    );
  end

  fpcmp_order #(.W(W)) u_order (
    .sign_a (sgn[0]), .mag_a (mag[0]), .nan_a (nan[0]), .zero_a (zero[0]),
    .sign_b (sgn[1]), .mag_b (mag[1]), .nan_b (nan[1]), .zero_b (zero[1]),
    .rel_o  (rel)
  );

  fpcmp_status u_status (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .cmp_signaling (cmp_signaling),
    .trap_nv_en    (trap_nv_en),
    .rel           (rel),
    .any_nan       (nan[0] || nan[1]),
    .any_snan      (snan[0] || snan[1]),
    .out_valid     (out_valid),
    .cc_o          (cc_o),
    .nv_o          (nv_o),
    .trap_o        (trap_o),
    .acc_nv_o      (acc_nv_o)
  );

  // R1: every accepted request is answered on the next edge
  p_valid_next_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R5: a signaling compare that finds no order must flag invalid
  p_sig_unord_nv_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cmp_signaling && rel == REL_UN) |=> nv_o);
  // R4: an ordered committed result never reports invalid
  p_ordered_no_nv_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !trap_o && cc_o != 2'd3) |-> !nv_o);
endmodule

// File: tb/fpcmp_cc_bench.sv
module fpcmp_cc_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        cmp_signaling = 1'b0;
  logic        trap_nv_en = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic        out_valid, nv_o, trap_o, acc_nv_o;
  logic [1:0]  cc_o;

  int checks = 0;
  int failures = 0;
  logic acc_model = 1'b0;

  always #4 clk = ~clk;

  fpcmp_cc #(.USE_DOUBLE(1'b0)) u_fpcmp_cc (
    .clk(clk), .rst(rst), .in_valid(in_valid), .cmp_signaling(cmp_signaling),
    .trap_nv_en(trap_nv_en), .op_a(op_a), .op_b(op_b), .out_valid(out_valid),
    .cc_o(cc_o), .nv_o(nv_o), .trap_o(trap_o), .acc_nv_o(acc_nv_o)
  );

  // {signaling, a, b, expected cc, expected nv}
  localparam int NV = 16;
  localparam logic [67:0] VEC [NV] = '{
    {1'b0, 32'h3F800000, 32'h40000000, 2'd1, 1'b0}, // R1 1<2
    {1'b0, 32'h40000000, 32'h3F800000, 2'd2, 1'b0}, // R1 2>1
    {1'b0, 32'h3F800000, 32'h3F800000, 2'd0, 1'b0}, // R1 equal
    {1'b0, 32'h00000000, 32'h80000000, 2'd0, 1'b0}, // R2 +0,-0
    {1'b0, 32'h80000000, 32'h00000000, 2'd0, 1'b0}, // R2 -0,+0
    {1'b0, 32'hBF800000, 32'hC0000000, 2'd2, 1'b0}, // R3 -1>-2
    {1'b0, 32'hC0000000, 32'hBF800000, 2'd1, 1'b0}, // R3 -2<-1
    {1'b0, 32'hBF800000, 32'h3F800000, 2'd1, 1'b0}, // R3 -1<1
    {1'b0, 32'h00000001, 32'h00000002, 2'd1, 1'b0}, // R3 subnormals
    {1'b0, 32'hFF800000, 32'h7F7FFFFF, 2'd1, 1'b0}, // R3 -inf<max
    {1'b1, 32'h80000001, 32'h00000000, 2'd1, 1'b0}, // R3 -sub<0
    {1'b0, 32'h7F800000, 32'h7F800000, 2'd0, 1'b0}, // R3 inf=inf
    {1'b1, 32'h3F800000, 32'h40000000, 2'd1, 1'b0}, // R5 ordered
    {1'b0, 32'h7FC00000, 32'h3F800000, 2'd3, 1'b0}, // R4 qNaN quiet
    {1'b0, 32'h3F800000, 32'h7FA00000, 2'd3, 1'b1}, // R4 sNaN quiet
    {1'b1, 32'h7FC00000, 32'h3F800000, 2'd3, 1'b1}  // R5 qNaN signaling
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic sig, input logic ten, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    cmp_signaling = sig; trap_nv_en = ten; op_a = a; op_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    acc_model = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    chk("R8 out_valid", out_valid, 0);
    chk("R8 cc", cc_o, 0);
    chk("R8 nv", nv_o, 0);
    chk("R8 trap", trap_o, 0);
    chk("R8 acc", acc_nv_o, 0);

    for (int i = 0; i < NV; i++) begin
      logic [67:0] v;
      v = VEC[i];
      issue(v[67], 1'b0, v[66:35], v[34:3]);
      if (v[2:1] == 2'd3 || v[0]) acc_model = 1'b1;
      chk("R1 out_valid", out_valid, 1);
      chk("R1/R2/R3 cc", cc_o, v[2:1]);
      chk("R4/R5 nv", nv_o, v[0]);
      chk("R6 acc", acc_nv_o, acc_model);
      chk("R7 no trap when disabled", trap_o, 0);
    end

    // R9: idle cycle keeps code and drops strobes
    @(negedge clk);
    chk("R9 out_valid idle", out_valid, 0);
    chk("R9 cc held", cc_o, 2'd3);
    chk("R9 nv idle", nv_o, 0);

    // R7: trapping sNaN leaves cc and acc alone
    do_reset();
    issue(1'b0, 1'b1, 32'h3F800000, 32'h40000000);
    chk("R7 ordered with trap enabled cc", cc_o, 2'd1);
    chk("R7 ordered no trap", trap_o, 0);
    issue(1'b0, 1'b1, 32'h7FA00000, 32'h3F800000);
    chk("R7 trap", trap_o, 1);
    chk("R7 nv", nv_o, 1);
    chk("R7 out_valid", out_valid, 1);
    chk("R7 cc held", cc_o, 2'd1);
    chk("R7 acc unchanged", acc_nv_o, 0);

    // R6: quiet NaN in quiet mode with trap enabled commits unordered and accrues
    issue(1'b0, 1'b1, 32'h7FC00000, 32'h3F800000);
    chk("R6 no trap for qNaN quiet", trap_o, 0);
    chk("R6 cc unordered", cc_o, 2'd3);
    chk("R6 acc set by unordered", acc_nv_o, 1);
    chk("R4 nv clear qNaN quiet", nv_o, 0);

    // R5: signaling mode qNaN with trap enabled traps
    issue(1'b1, 1'b1, 32'h3F800000, 32'h7FC00000);
    chk("R5 trap on qNaN signaling", trap_o, 1);
    // R6: accrued stays set after an ordered result
    issue(1'b0, 1'b0, 32'h40000000, 32'h3F800000);
    chk("R6 acc sticky", acc_nv_o, 1);
    chk("R1 cc after sticky", cc_o, 2'd2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule